// File: doc/BRIEF.md
# Ethernet receive frame status classifier

This block sits behind a byte-wide receive front end and watches each incoming frame as it streams past. The stream carries a per-byte valid, the data byte, a receive-error flag, a collision flag, a count of leftover dribble bits and a CRC-good flag from an external checker. At the end of each frame the block emits an 8-bit status word, the number of bytes counted and a one-cycle strobe.

The status word holds seven condition bits: over-length, late collision, type-versus-length, watchdog expiry, line error, dribble and CRC error. They are not independent. Short frames, late collisions and watchdog expiry each hide the CRC verdict. Late collisions and watchdog expiry also hide the dribble report. At 10 Mb/s a dribble is reported only when enough stray bits are present.

A frame that runs past the watchdog limit is cut off at once. The limit comes from a live input, clamped into a fixed window. Its status is emitted without waiting for the stream to stop, and the rest of that frame is discarded.

Top module: `rx_frame_status`

## Requirements
- R1: After reset, stat_valid_o, stat_o and byte_cnt_o are all 0.
- R2: When frm_valid_i falls after a frame, stat_valid_o is high for exactly one cycle, registered at the first clock edge that samples frm_valid_i low. byte_cnt_o then equals the number of bytes in the frame, and exactly one strobe occurs per frame.
- R3: stat_o[7] (over-length) is 1 exactly when the counted length exceeds 1518 bytes. The frame is still counted in full.
- R4: stat_o[6] (late collision) is 1 when col_i is high on any counted byte whose zero-based index is 64 or more. A collision on bytes 0 to 63 sets nothing.
- R5: stat_o[5] (type frame) is 1 when the 16-bit value formed from byte 12 (high half) and byte 13 (low half) is greater than 1500 and the frame has at least 14 bytes. Otherwise it is 0.
- R6: The watchdog limit is wdog_limit_i clamped into 2048..2560. If a byte arrives when the limit number of bytes has already been counted, the status is emitted at that clock edge with stat_o[4] set and byte_cnt_o equal to the limit. The remaining bytes of that frame produce no further strobe. A frame of exactly the limit length does not trip the watchdog.
- R7: stat_o[3] (line error) is 1 when rx_err_i was high on any counted byte.
- R8: stat_o[2] (dribble) reflects drib_bits_i on the last counted byte. It is 1 when that value is nonzero, and at 10 Mb/s (speed_10m_i=1) only when it is 3 or more. It is forced to 0 when stat_o[6] or stat_o[4] is set.
- R9: stat_o[1] (CRC error) is 1 when crc_ok_i was low on the last counted byte or rx_err_i was high on any counted byte. It is forced to 0 for frames under 64 bytes, for late collisions and for watchdog expiry.
- R10: stat_o[0] is always 0. drib_bits_i and crc_ok_i on bytes other than the last have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_valid_i | input | 1 | High for each byte of a frame; low for at least one cycle between frames |
| data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error on this byte |
| col_i | input | 1 | Collision seen on this byte |
| drib_bits_i | input | 3 | Leftover bit count, meaningful on the last byte |
| crc_ok_i | input | 1 | External CRC verdict, meaningful on the last byte |
| speed_10m_i | input | 1 | 1 selects 10 Mb/s dribble threshold |
| wdog_limit_i | input | 12 | Requested watchdog byte limit (clamped) |
| stat_valid_o | output | 1 | One-cycle status strobe |
| stat_o | output | 8 | Status word, bits as in R3 to R10 |
| byte_cnt_o | output | 12 | Counted frame length |

## Verification
The bench builds the block with its default parameters: 12-bit counter, 1518-byte maximum, 64-byte runt and collision window, 2048 to 2560 watchdog window. With these values the over-length and watchdog boundaries are reachable with frames of a few thousand cycles. Driving wdog_limit_i at 1000, 2048, 2560 and 3000 exercises both clamp edges as well as in-range values. Random short frames mix errors, collisions, dribble counts and CRC verdicts so the masking rules meet each other.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef struct packed {
    logic too_long;
    logic late_col;
    logic eth_type;
    logic wdog;
    logic line_err;
    logic dribble;
    logic crc_err;
    logic rsvd;
  } rx_stat_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DROP} rx_state_e;
endpackage

// File: rtl/rxs_byte_counter.sv
module rxs_byte_counter #(
  parameter int CNT_W   = 12,
  parameter int MAX_CNT = 2560
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_lim_o
);
  localparam logic [CNT_W-1:0] MaxC = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_lim_o = (cnt_q == lim_i);

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MaxC);
endmodule

// File: rtl/rxs_field_tracker.sv
module rxs_field_tracker #(
  parameter int CNT_W    = 12,
  parameter int DRIB_W   = 3,
  parameter int TYPE_POS = 12,
  parameter int COL_WIN  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              first_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [7:0]        data_i,
  input  logic              rx_err_i,
  input  logic              col_i,
  input  logic [DRIB_W-1:0] drib_i,
  input  logic              crc_ok_i,
  output logic [15:0]       type_o,
  output logic              err_o,
  output logic              late_col_o,
  output logic [DRIB_W-1:0] drib_o,
  output logic              crc_ok_o
);
  localparam logic [CNT_W-1:0] PosHi = CNT_W'(TYPE_POS);
  localparam logic [CNT_W-1:0] PosLo = CNT_W'(TYPE_POS + 1);
  localparam logic [CNT_W-1:0] ColW  = CNT_W'(COL_WIN);

  logic late_now;
  assign late_now = col_i && (cnt_i >= ColW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_o     <= '0;
      err_o      <= 1'b0;
      late_col_o <= 1'b0;
      drib_o     <= '0;
      crc_ok_o   <= 1'b1;
    end else if (acc_i) begin
      // tail fields always follow the newest byte
      drib_o   <= drib_i;
      crc_ok_o <= crc_ok_i;
      if (first_i) begin
        type_o     <= '0;
        err_o      <= rx_err_i;
        late_col_o <= late_now;
      end else begin
        err_o      <= err_o | rx_err_i;
        late_col_o <= late_col_o | late_now;
        if (cnt_i == PosHi) type_o[15:8] <= data_i;
        if (cnt_i == PosLo) type_o[7:0]  <= data_i;
      end
    end
  end
endmodule

// File: rtl/rxs_status_encoder.sv
module rxs_status_encoder
  import rxs_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DRIB_W    = 3,
  parameter int MAX_LEN   = 1518,
  parameter int RUNT_LEN  = 64,
  parameter int TYPE_POS  = 12,
  parameter int TYPE_THR  = 1500,
  parameter int DRIB_MIN  = 3
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [15:0]       type_i,
  input  logic              err_i,
  input  logic              late_col_i,
  input  logic [DRIB_W-1:0] drib_i,
  input  logic              crc_ok_i,
  input  logic              speed_10m_i,
  input  logic              wdog_i,
  output rx_stat_t          stat_o
);
  localparam logic [CNT_W-1:0]  MaxL   = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0]  RuntL  = CNT_W'(RUNT_LEN);
  localparam logic [CNT_W-1:0]  TypeL  = CNT_W'(TYPE_POS + 2);
  localparam logic [15:0]       TypeT  = 16'(TYPE_THR);
  localparam logic [DRIB_W-1:0] DribM  = DRIB_W'(DRIB_MIN);

  logic runt, drib_seen, crc_bad;

  always_comb begin
    runt      = cnt_i < RuntL;
    drib_seen = (drib_i != '0) && (!speed_10m_i || drib_i >= DribM);
    crc_bad   = !crc_ok_i || err_i;

    stat_o          = '0;
    stat_o.too_long = cnt_i > MaxL;
    stat_o.late_col = late_col_i;
    stat_o.eth_type = (cnt_i >= TypeL) && (type_i > TypeT);
    stat_o.wdog     = wdog_i;
    stat_o.line_err = err_i;
    stat_o.dribble  = drib_seen && !late_col_i && !wdog_i;
    stat_o.crc_err  = crc_bad && !runt && !late_col_i && !wdog_i;
  end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rxs_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DRIB_W   = 3,
  parameter int MAX_LEN  = 1518,
  parameter int RUNT_LEN = 64,
  parameter int COL_WIN  = 64,
  parameter int TYPE_POS = 12,
  parameter int TYPE_THR = 1500,
  parameter int DRIB_MIN = 3,
  parameter int WDOG_MIN = 2048,
  parameter int WDOG_MAX = 2560
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic [7:0]        data_i,
  input  logic              rx_err_i,
  input  logic              col_i,
  input  logic [DRIB_W-1:0] drib_bits_i,
  input  logic              crc_ok_i,
  input  logic              speed_10m_i,
  input  logic [CNT_W-1:0]  wdog_limit_i,
  output logic              stat_valid_o,
  output logic [7:0]        stat_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  localparam logic [CNT_W-1:0] WdMin = CNT_W'(WDOG_MIN);
  localparam logic [CNT_W-1:0] WdMax = CNT_W'(WDOG_MAX);
  localparam logic [CNT_W-1:0] RuntL = CNT_W'(RUNT_LEN);
  localparam logic [CNT_W-1:0] TypeL = CNT_W'(TYPE_POS + 2);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] lim_c, cnt;
  logic             at_lim, accept, first, wd_hit, end_ok, emit;
  logic [15:0]      type_f;
  logic             err_f, late_f, crc_f;
  logic [DRIB_W-1:0] drib_f;
  rx_stat_t         enc;

  always_comb begin
    if (wdog_limit_i < WdMin)      lim_c = WdMin;
    else if (wdog_limit_i > WdMax) lim_c = WdMax;
    else                           lim_c = wdog_limit_i;
  end

  assign first  = (state_q == ST_IDLE);
  assign accept = frm_valid_i && (first || (state_q == ST_RECV && !at_lim));
  assign wd_hit = (state_q == ST_RECV) && frm_valid_i && at_lim;
  assign end_ok = (state_q == ST_RECV) && !frm_valid_i;
  assign emit   = wd_hit || end_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (frm_valid_i) state_d = ST_RECV;
      ST_RECV: if (wd_hit) state_d = ST_DROP;
               else if (end_ok) state_d = ST_IDLE;
      ST_DROP: if (!frm_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  rxs_byte_counter #(.CNT_W(CNT_W), .MAX_CNT(WDOG_MAX)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i   (emit),
    .inc_i   (accept),
    .lim_i   (lim_c),
    .cnt_o   (cnt),
    .at_lim_o(at_lim)
  );

  rxs_field_tracker #(
    .CNT_W(CNT_W), .DRIB_W(DRIB_W), .TYPE_POS(TYPE_POS), .COL_WIN(COL_WIN)
  ) u_trk (
    .clk_i, .rst_ni,
    .acc_i     (accept),
    .first_i   (first),
    .cnt_i     (cnt),
    .data_i,
    .rx_err_i,
    .col_i,
    .drib_i    (drib_bits_i),
    .crc_ok_i,
    .type_o    (type_f),
    .err_o     (err_f),
    .late_col_o(late_f),
    .drib_o    (drib_f),
    .crc_ok_o  (crc_f)
  );

  rxs_status_encoder #(
    .CNT_W(CNT_W), .DRIB_W(DRIB_W), .MAX_LEN(MAX_LEN), .RUNT_LEN(RUNT_LEN),
    .TYPE_POS(TYPE_POS), .TYPE_THR(TYPE_THR), .DRIB_MIN(DRIB_MIN)
  ) u_enc (
    .cnt_i      (cnt),
    .type_i     (type_f),
    .err_i      (err_f),
    .late_col_i (late_f),
    .drib_i     (drib_f),
    .crc_ok_i   (crc_f),
    .speed_10m_i,
    .wdog_i     (wd_hit),
    .stat_o     (enc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      stat_valid_o <= 1'b0;
      stat_o       <= '0;
      byte_cnt_o   <= '0;
    end else begin
      state_q      <= state_d;
      stat_valid_o <= emit;
      if (emit) begin
        stat_o     <= enc;
        byte_cnt_o <= cnt;
      end
    end
  end

  assert_one_cycle_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);
  assert_runt_no_crc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && byte_cnt_o < RuntL) |-> !stat_o[1]);
  assert_wdog_no_crc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_o[4]) |-> !stat_o[1]);
  assert_late_no_drib_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_o[6]) |-> !stat_o[2]);
  assert_type_min_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_o[5]) |-> byte_cnt_o >= TypeL);
  assert_wdog_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_o[4]) |-> (byte_cnt_o >= WdMin && byte_cnt_o <= WdMax));
endmodule

// File: tb/rx_frame_status_tb_top.sv
`timescale 1ns/1ps
module rx_frame_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [7:0]  data = '0;
  logic        rx_err = 1'b0, col = 1'b0, crc_ok = 1'b1, sp10 = 1'b0;
  logic [2:0]  drib = '0;
  logic [11:0] wlim = 12'd2048;
  logic        sv;
  logic [7:0]  st;
  logic [11:0] bc;

  int errors = 0, checks = 0;
  int strobes = 0, rsvd_hits = 0;
  logic [7:0]  last_st;
  logic [11:0] last_bc;

  always #2 clk = ~clk;

  rx_frame_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frm_valid_i(frm_valid), .data_i(data),
    .rx_err_i(rx_err), .col_i(col), .drib_bits_i(drib), .crc_ok_i(crc_ok),
    .speed_10m_i(sp10), .wdog_limit_i(wlim),
    .stat_valid_o(sv), .stat_o(st), .byte_cnt_o(bc)
  );

  always @(negedge clk) if (rst_n && sv) begin
    strobes++;
    last_st = st;
    last_bc = bc;
    if (st[0]) rsvd_hits++;
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int clamp_lim(int l);
    if (l < 2048) return 2048;
    if (l > 2560) return 2560;
    return l;
  endfunction

  function automatic int exp_stat(int len, int typ, int ep, int cp, int dr,
                                  int ok, int s10, int lim, output int n);
    int wd, err, late, ty, tl, db, ce;
    wd   = (len > lim) ? 1 : 0;
    n    = wd ? lim : len;
    err  = (ep >= 0 && ep < n) ? 1 : 0;
    late = (cp >= 64 && cp < n) ? 1 : 0;
    ty   = (n >= 14 && typ > 1500) ? 1 : 0;
    tl   = (n > 1518) ? 1 : 0;
    db   = (!wd && !late && dr != 0 && (!s10 || dr >= 3)) ? 1 : 0;
    ce   = (!wd && !late && n >= 64 && (!ok || err)) ? 1 : 0;
    return (tl << 7) | (late << 6) | (ty << 5) | (wd << 4) | (err << 3) |
           (db << 2) | (ce << 1);
  endfunction

  task automatic frame(string req, int len, int typ, int ep, int cp, int dr,
                       int ok, int s10, int wl);
    int s0, n, es, lim;
    lim = clamp_lim(wl);
    @(negedge clk);
    wlim = 12'(wl);
    sp10 = s10[0];
    s0   = strobes;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frm_valid = 1'b1;
      data   = (i == 12) ? 8'(typ >> 8) : (i == 13) ? 8'(typ) : 8'($urandom);
      rx_err = (i == ep);
      col    = (i == cp);
      drib   = (i == len - 1) ? 3'(dr) : 3'($urandom);
      crc_ok = (i == len - 1) ? ok[0] : 1'($urandom);
    end
    @(negedge clk);
    frm_valid = 1'b0; rx_err = 1'b0; col = 1'b0;
    repeat (4) @(negedge clk);
    es = exp_stat(len, typ, ep, cp, dr, ok, s10, lim, n);
    check({req, " R2 strobes"}, strobes - s0, 1);
    check({req, " status"}, int'(last_st), es);
    check({req, " R2 count"}, int'(last_bc), n);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 valid", int'(sv), 0);
    check("R1 stat", int'(st), 0);
    check("R1 count", int'(bc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    frame("R2 min good",    64, 16'h0800, -1, -1, 0, 1, 0, 2048);
    frame("R9 runt badcrc", 20, 16'h0800, -1, -1, 0, 0, 0, 2048);
    frame("R9 64 badcrc",   64, 16'h0040, -1, -1, 0, 0, 0, 2048);
    frame("R5 13 bytes",    13, 16'hffff, -1, -1, 0, 1, 0, 2048);
    frame("R5 14 bytes",    14, 1501,     -1, -1, 0, 1, 0, 2048);
    frame("R5 len 1500",    80, 1500,     -1, -1, 0, 1, 0, 2048);
    frame("R3 1518",      1518, 16'h0800, -1, -1, 0, 1, 0, 2048);
    frame("R3 1519",      1519, 16'h0800, -1, -1, 0, 1, 0, 2048);
    frame("R4 late 64",    100, 16'h0800, -1, 64, 5, 0, 0, 2048);
    frame("R4 early 63",   100, 16'h0800, -1, 63, 0, 1, 0, 2048);
    frame("R7 rxerr okcrc",100, 16'h0800, 70, -1, 0, 1, 0, 2048);
    frame("R7 rxerr runt",  30, 16'h0800,  3, -1, 0, 1, 0, 2048);
    frame("R8 10M two",     70, 16'h0800, -1, -1, 2, 1, 1, 2048);
    frame("R8 10M three",   70, 16'h0800, -1, -1, 3, 1, 1, 2048);
    frame("R8 100M one",    70, 16'h0800, -1, -1, 1, 1, 0, 2048);
    frame("R6 at limit",  2048, 16'h0800, -1, -1, 4, 0, 0, 2048);
    frame("R6 over 2048", 2100, 16'h0800, -1, -1, 4, 0, 0, 2048);
    frame("R6 clamp low", 2049, 16'h0800, -1, -1, 0, 1, 0, 1000);
    frame("R6 2560 ok",   2500, 16'h0800, -1, -1, 0, 1, 0, 2560);
    frame("R6 clamp high",2600, 16'h0800, 10, -1, 0, 1, 0, 3000);
    frame("R10 after wd",   64, 16'h0800, -1, -1, 0, 1, 0, 2048);

    for (int k = 0; k < 40; k++) begin
      int len, ep, cp;
      len = ($urandom % 8 == 0) ? 1400 + int'($urandom % 300) : 1 + int'($urandom % 150);
      ep  = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
      cp  = ($urandom % 4 == 0) ? int'($urandom % len) : -1;
      frame("R4 R7 R8 R9 random", len, int'($urandom % 65536), ep, cp,
            int'($urandom % 8), int'($urandom % 2), int'($urandom % 2), 2048);
    end

    check("R10 reserved bit", rsvd_hits, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule